// File: doc/BRIEF.md
# Reset Source Sequencer

This block collects three kinds of reset request and turns them into one synchronous internal reset for the rest of the chip. The three requests are a long enough low level on the active-low reset pin, a software write of 0 to a control bit, and a bus access that the ready line has stretched for too long. A pin request that arrives while a write is in flight is held back until the write ends, so that the write completes cleanly. If the bus is stalled, the held request is forced through once the stall has lasted a fixed number of machine cycles.

Every accepted reset keeps the internal reset high for a minimum number of machine cycles. The pin also extends the reset for as long as it stays low. A pin reset taken while the clock mode is stop or sub-clock then adds an oscillator-settling wait, counted in oscillator clocks (`clk`), before release. A sticky cause register records which source fired. The machine-cycle rate is given by a one-clock strobe, `mcyc_en`.

The sequencer has four states:
- IDLE: no reset is active.
- DEFER: a pin request is waiting for a write to end.
- HOLD: the internal reset is asserted for the minimum time and for as long as the pin stays low.
- STAB: the settling wait.

The transitions are:
- IDLE→HOLD on a pin request that is not blocked, or on a pending software request.
- IDLE→DEFER on a pin request during a write, when no stall is forcing acceptance.
- DEFER→HOLD when the write ends or a stall forces acceptance.
- HOLD→STAB when the minimum time is done, the pin is high and the settling wait was latched.
- HOLD→IDLE on the same condition when no settling wait was latched.
- STAB→IDLE when the settling count is done.
- Asynchronous `arst_n` puts the block in HOLD.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After a two-flop synchronizer, the pin low level is counted in `mcyc_en` strobes. A low period that spans PIN_MIN_MC (16) strobes raises `int_rst` and sets cause bit 0. A shorter low period raises neither, and the count clears whenever the pin goes high.
- R2: While the synchronized pin stays low, an active `int_rst` is not released.
- R3: Each accepted reset holds `int_rst` high for at least HOLD_MC (4) machine-cycle strobes.
- R4: A pulse on `ctl_wr` with `ctl_wdata`=0 starts a software reset and sets cause bit 1. `swrst_rb` reads 0 from the write until the sequence starts, and 1 from then on. A write of 1 has no effect, and writes made while `int_rst` is high are ignored.
- R5: A software reset never inserts the settling wait, whatever the `clk_mode`.
- R6: In `clk_mode` 2'b00 (run) or 2'b11 (treated as run), a pin reset releases within a few clocks once the pin is high and the minimum hold is done.
- R7: In `clk_mode` 2'b01 (stop) or 2'b10 (sub-clock), as sampled at acceptance, a pin reset keeps `int_rst` high for at least 2^STAB_LOG2 further `clk` cycles after the hold.
- R8: A pin request made while `wr_busy` is high is not accepted until `wr_busy` falls, unless R9 applies.
- R9: When `bus_ext`=1 and `bus_rdy`=0 have held for STALL_MC (16) consecutive strobes, a held pin request is accepted even with `wr_busy` high, and cause bit 2 is set.
- R10: Cause bits (bit 0 pin, bit 1 software, bit 2 forced by stall) are sticky and survive `int_rst`. A `cause_clr_wr` pulse clears each bit whose `cause_clr_data` bit is 1, and a set in the same cycle wins.
- R11: While `arst_n` is low, `int_rst`=1, the cause flags are 0 and `swrst_rb`=1. After `arst_n` rises, reset releases after the minimum hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| mcyc_en | input | 1 | One-clock strobe per machine cycle |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| ctl_wr | input | 1 | Write strobe for the software reset bit |
| ctl_wdata | input | 1 | Value written to the software reset bit |
| cause_clr_wr | input | 1 | Write strobe for the cause register |
| cause_clr_data | input | 3 | Write-1-to-clear mask for the cause bits |
| wr_busy | input | 1 | A write operation is in progress |
| bus_ext | input | 1 | An external bus access is in progress |
| bus_rdy | input | 1 | Bus ready; low stretches the access |
| clk_mode | input | 2 | 00 run, 01 stop, 10 sub-clock, 11 run |
| int_rst | output | 1 | Synchronous internal reset, active high |
| cause_flags | output | 3 | Sticky cause bits {stall, software, pin} |
| swrst_rb | output | 1 | Read-back of the software reset bit |

## Verification
The assertions watch the following on every cycle:
- the minimum hold length, and the settling length when it was latched;
- that nothing is released while a deferral is blocked;
- that the cause bits stay set unless cleared;
- that the software bit reads 1 when reset starts;
- that the stall flag appears only after a forced acceptance.

Other behaviour needs the bench's scenarios:
- the exact 15-versus-16 strobe boundary of the pin filter;
- the hold extended by a long pin low;
- writes ignored during reset;
- the absence of a settling wait for software resets in stop mode;
- release timing under randomly chosen pulse lengths and clock modes.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_STOP = 2'b01,
        MODE_SUB  = 2'b10,
        MODE_RSVD = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DEFER,
        ST_HOLD,
        ST_STAB
    } seq_state_e;

    localparam int CAUSE_W     = 3;
    localparam int CAUSE_PIN   = 0;
    localparam int CAUSE_SW    = 1;
    localparam int CAUSE_STALL = 2;

    function automatic logic mode_needs_stab(input logic [1:0] mode);
        return (mode == MODE_STOP) || (mode == MODE_SUB);
    endfunction

endpackage

// File: rtl/rsc_pin_filter.sv
// Synchronizes the reset pin and measures its low time in machine cycles.
module rsc_pin_filter #(
    parameter int PIN_MIN_MC = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic mc_tick,
    input  logic pin_n,
    output logic pin_low,
    output logic pin_req
);
    localparam int CW = $clog2(PIN_MIN_MC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], pin_n};
        end
    end

    assign pin_low = !sync_q[1];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            low_cnt <= '0;
        end else if (!pin_low) begin
            low_cnt <= '0;
        end else if (mc_tick && (low_cnt != CW'(PIN_MIN_MC))) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // One pulse per low period, on the strobe that completes the minimum.
    assign pin_req = pin_low && mc_tick && (low_cnt == CW'(PIN_MIN_MC - 1));

endmodule

// File: rtl/rsc_stall_mon.sv
// Counts consecutive machine cycles of a ready-stretched external access.
module rsc_stall_mon #(
    parameter int STALL_MC = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic mc_tick,
    input  logic bus_ext,
    input  logic bus_rdy,
    output logic stall_force
);
    localparam int CW = $clog2(STALL_MC + 1);

    logic [CW-1:0] stall_cnt;
    logic          stalled;

    assign stalled = bus_ext && !bus_rdy;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stall_cnt <= '0;
        end else if (!stalled) begin
            stall_cnt <= '0;
        end else if (mc_tick && (stall_cnt != CW'(STALL_MC))) begin
            stall_cnt <= stall_cnt + 1'b1;
        end
    end

    assign stall_force = stalled && (stall_cnt == CW'(STALL_MC));

endmodule

// File: rtl/rsc_cause_reg.sv
// Software reset bit and sticky cause flags.
module rsc_cause_reg
    import rsc_pkg::*;
(
    input  logic               clk,
    input  logic               arst_n,
    input  logic               wr_allow,
    input  logic               sw_wr,
    input  logic               sw_wdata,
    input  logic               sw_restore,
    input  logic               clr_wr,
    input  logic [CAUSE_W-1:0] clr_data,
    input  logic [CAUSE_W-1:0] cause_set,
    output logic               sw_bit,
    output logic [CAUSE_W-1:0] cause_q
);
    logic [CAUSE_W-1:0] clr_mask;

    assign clr_mask = clr_wr ? clr_data : '0;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sw_bit <= 1'b1;
        end else if (sw_restore) begin
            sw_bit <= 1'b1;
        end else if (sw_wr && wr_allow && !sw_wdata) begin
            sw_bit <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= (cause_q & ~clr_mask) | cause_set;
        end
    end

endmodule

// File: rtl/rsc_seq_fsm.sv
// Acceptance, hold and settling sequencer.
module rsc_seq_fsm
    import rsc_pkg::*;
#(
    parameter int HOLD_MC   = 4,
    parameter int STAB_LOG2 = 17
) (
    input  logic               clk,
    input  logic               arst_n,
    input  logic               mc_tick,
    input  logic               pin_req,
    input  logic               pin_low,
    input  logic               sw_pend,
    input  logic               wr_busy,
    input  logic               stall_force,
    input  logic [1:0]         clk_mode,
    output logic               int_rst,
    output logic               accept,
    output logic               in_defer,
    output logic               stab_q,
    output logic [CAUSE_W-1:0] cause_set
);
    localparam int HW = $clog2(HOLD_MC + 1);

    seq_state_e           state_q, state_d;
    logic [HW-1:0]        hold_cnt;
    logic [STAB_LOG2-1:0] stab_cnt;
    logic                 hold_done, stab_done;
    logic                 pin_src, forced;

    assign hold_done = (hold_cnt == HW'(HOLD_MC));
    assign stab_done = &stab_cnt;

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        pin_src = 1'b0;
        forced  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pin_req) begin
                    if (wr_busy && !stall_force) begin
                        state_d = ST_DEFER;
                    end else begin
                        state_d = ST_HOLD;
                        pin_src = 1'b1;
                        forced  = wr_busy;
                    end
                end else if (sw_pend) begin
                    state_d = ST_HOLD;
                end
            end
            ST_DEFER: begin
                if (!wr_busy || stall_force) begin
                    state_d = ST_HOLD;
                    pin_src = 1'b1;
                    forced  = wr_busy;
                end
            end
            ST_HOLD: begin
                if (hold_done && !pin_low) begin
                    state_d = stab_q ? ST_STAB : ST_IDLE;
                end
            end
            ST_STAB: begin
                if (stab_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        int_rst   = (state_q == ST_HOLD) || (state_q == ST_STAB);
        in_defer  = (state_q == ST_DEFER);
        accept    = ((state_q == ST_IDLE) || (state_q == ST_DEFER)) && (state_d == ST_HOLD);
        cause_set = '0;
        if (accept) begin
            cause_set[CAUSE_PIN]   = pin_src;
            cause_set[CAUSE_SW]    = sw_pend;
            cause_set[CAUSE_STALL] = forced;
        end
    end

    // Hold counter and settling latch
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hold_cnt <= '0;
            stab_q   <= 1'b0;
        end else if (accept) begin
            hold_cnt <= '0;
            stab_q   <= pin_src && mode_needs_stab(clk_mode);
        end else if ((state_q == ST_HOLD) && mc_tick && !hold_done) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Settling counter, in oscillator clocks
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stab_cnt <= '0;
        end else if (state_q != ST_STAB) begin
            stab_cnt <= '0;
        end else begin
            stab_cnt <= stab_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int PIN_MIN_MC = 16,
    parameter int STALL_MC   = 16,
    parameter int HOLD_MC    = 4,
    parameter int STAB_LOG2  = 17
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         mcyc_en,
    input  logic         ext_rst_n,
    input  logic         ctl_wr,
    input  logic         ctl_wdata,
    input  logic         cause_clr_wr,
    input  logic [2:0]   cause_clr_data,
    input  logic         wr_busy,
    input  logic         bus_ext,
    input  logic         bus_rdy,
    input  logic [1:0]   clk_mode,
    output logic         int_rst,
    output logic [2:0]   cause_flags,
    output logic         swrst_rb
);
    logic               pin_low, pin_req, stall_force;
    logic               accept, fsm_defer, stab_q, sw_bit;
    logic [CAUSE_W-1:0] cause_set;

    rsc_pin_filter #(.PIN_MIN_MC(PIN_MIN_MC)) u_pin (
        .clk     (clk),
        .arst_n  (arst_n),
        .mc_tick (mcyc_en),
        .pin_n   (ext_rst_n),
        .pin_low (pin_low),
        .pin_req (pin_req)
    );

    rsc_stall_mon #(.STALL_MC(STALL_MC)) u_stall (
        .clk         (clk),
        .arst_n      (arst_n),
        .mc_tick     (mcyc_en),
        .bus_ext     (bus_ext),
        .bus_rdy     (bus_rdy),
        .stall_force (stall_force)
    );

    rsc_seq_fsm #(.HOLD_MC(HOLD_MC), .STAB_LOG2(STAB_LOG2)) u_fsm (
        .clk         (clk),
        .arst_n      (arst_n),
        .mc_tick     (mcyc_en),
        .pin_req     (pin_req),
        .pin_low     (pin_low),
        .sw_pend     (!sw_bit),
        .wr_busy     (wr_busy),
        .stall_force (stall_force),
        .clk_mode    (clk_mode),
        .int_rst     (int_rst),
        .accept      (accept),
        .in_defer    (fsm_defer),
        .stab_q      (stab_q),
        .cause_set   (cause_set)
    );

    rsc_cause_reg u_cause (
        .clk        (clk),
        .arst_n     (arst_n),
        .wr_allow   (!int_rst),
        .sw_wr      (ctl_wr),
        .sw_wdata   (ctl_wdata),
        .sw_restore (accept),
        .clr_wr     (cause_clr_wr),
        .clr_data   (cause_clr_data),
        .cause_set  (cause_set),
        .sw_bit     (sw_bit),
        .cause_q    (cause_flags)
    );

    assign swrst_rb = sw_bit;

endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
    parameter int HOLD_MC   = 4,
    parameter int STAB_LOG2 = 17
) (
    input logic       clk,
    input logic       arst_n,
    input logic       mc_tick,
    input logic       int_rst,
    input logic       swrst_rb,
    input logic [2:0] cause_flags,
    input logic       cause_clr_wr,
    input logic [2:0] cause_clr_data,
    input logic       wr_busy,
    input logic       in_defer,
    input logic       stall_force,
    input logic       stab_q
);
    logic [7:0]           mc_cnt;
    logic [STAB_LOG2+1:0] clk_cnt;
    logic [2:0]           keep_mask;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            mc_cnt  <= '0;
            clk_cnt <= '0;
        end else if (!int_rst) begin
            mc_cnt  <= '0;
            clk_cnt <= '0;
        end else begin
            if (mc_tick && (mc_cnt != 8'hFF)) mc_cnt <= mc_cnt + 1'b1;
            if (!(&clk_cnt)) clk_cnt <= clk_cnt + 1'b1;
        end
    end

    assign keep_mask = cause_flags & ~(cause_clr_wr ? cause_clr_data : 3'b000);

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(int_rst) |-> (mc_cnt >= 8'(HOLD_MC))); // R3

    AST_STAB_LENGTH: assert property (@(posedge clk) disable iff (!arst_n)
        ($fell(int_rst) && stab_q) |-> (clk_cnt[STAB_LOG2+1:STAB_LOG2] != 2'b00)); // R7

    AST_DEFER_BLOCKS: assert property (@(posedge clk) disable iff (!arst_n)
        (in_defer && wr_busy && !stall_force) |=> !int_rst); // R8

    AST_SW_READBACK: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(int_rst) |-> swrst_rb); // R4

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
        (keep_mask != 3'b000) |=> ((cause_flags & $past(keep_mask)) == $past(keep_mask))); // R10

    AST_STALL_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(cause_flags[2]) |-> $past(stall_force)); // R9

endmodule

bind rst_seq_ctrl rsc_chk #(.HOLD_MC(HOLD_MC), .STAB_LOG2(STAB_LOG2)) u_chk (
    .clk            (clk),
    .arst_n         (arst_n),
    .mc_tick        (mcyc_en),
    .int_rst        (int_rst),
    .swrst_rb       (swrst_rb),
    .cause_flags    (cause_flags),
    .cause_clr_wr   (cause_clr_wr),
    .cause_clr_data (cause_clr_data),
    .wr_busy        (wr_busy),
    .in_defer       (fsm_defer),
    .stall_force    (stall_force),
    .stab_q         (stab_q)
);

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;
    localparam int PIN_MC    = 16;
    localparam int STALL_MC  = 16;
    localparam int HOLD_MC   = 4;
    localparam int STAB_LOG2 = 8;
    localparam int STAB_CLK  = 1 << STAB_LOG2;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       mcyc_en = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       ctl_wr = 1'b0;
    logic       ctl_wdata = 1'b1;
    logic       cause_clr_wr = 1'b0;
    logic [2:0] cause_clr_data = 3'b000;
    logic       wr_busy = 1'b0;
    logic       bus_ext = 1'b0;
    logic       bus_rdy = 1'b1;
    logic [1:0] clk_mode = 2'b00;
    logic       int_rst;
    logic [2:0] cause_flags;
    logic       swrst_rb;

    int          n_tests = 0;
    int          n_fail  = 0;
    int unsigned rst_clks = 0;
    logic [1:0]  div = 2'd0;

    // 20-unit period: 50 MHz with 1 ns units
    always #10 clk = ~clk;

    // Machine cycle = four oscillator clocks
    always @(negedge clk) begin
        div     <= div + 2'd1;
        mcyc_en <= (div == 2'd3);
    end

    always @(posedge clk) rst_clks <= rst_clks + (int_rst ? 32'd1 : 32'd0);

    rst_seq_ctrl #(
        .PIN_MIN_MC(PIN_MC), .STALL_MC(STALL_MC),
        .HOLD_MC(HOLD_MC), .STAB_LOG2(STAB_LOG2)
    ) uut (
        .clk(clk), .arst_n(arst_n), .mcyc_en(mcyc_en), .ext_rst_n(ext_rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cause_clr_wr(cause_clr_wr), .cause_clr_data(cause_clr_data),
        .wr_busy(wr_busy), .bus_ext(bus_ext), .bus_rdy(bus_rdy),
        .clk_mode(clk_mode), .int_rst(int_rst),
        .cause_flags(cause_flags), .swrst_rb(swrst_rb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while ((int_rst === 1'b1) && (n < 5000)) begin
            tick(1);
            n++;
        end
    endtask

    task automatic pin_pulse(input int mc);
        ext_rst_n = 1'b0;
        tick(mc * 4);
        ext_rst_n = 1'b1;
    endtask

    task automatic sw_write(input logic v);
        ctl_wdata = v;
        ctl_wr    = 1'b1;
        tick(1);
        ctl_wr    = 1'b0;
        ctl_wdata = 1'b1;
    endtask

    task automatic clr_flags(input logic [2:0] m);
        cause_clr_data = m;
        cause_clr_wr   = 1'b1;
        tick(1);
        cause_clr_wr   = 1'b0;
        cause_clr_data = 3'b000;
    endtask

    function automatic bit exp_accept(input int mc);
        return mc >= PIN_MC;
    endfunction

    function automatic bit exp_wait(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        int unsigned snap;
        int unsigned seed_v;

        seed_v = $urandom(77);

        // R11: state under asynchronous reset
        tick(3);
        chk(int_rst == 1'b1, "R11 int_rst in reset", int'(int_rst), 1);
        chk(cause_flags == 3'b000, "R11 flags in reset", int'(cause_flags), 0);
        chk(swrst_rb == 1'b1, "R11 sw bit in reset", int'(swrst_rb), 1);
        arst_n = 1'b1;
        wait_release(n);
        chk(n <= 30, "R11 release after power-on", n, 30);

        // R1: 15 strobes is too short
        snap = rst_clks;
        pin_pulse(15);
        tick(6);
        chk(rst_clks == snap, "R1 short pulse ignored", int'(rst_clks - snap), 0);
        chk(cause_flags[0] == 1'b0, "R1 no pin flag", int'(cause_flags[0]), 0);

        // R1: exactly 16 strobes is accepted
        pin_pulse(16);
        tick(4);
        chk(int_rst == 1'b1, "R1 16-cycle pulse", int'(int_rst), 1);
        wait_release(n);
        chk(cause_flags[0] == 1'b1, "R1 pin flag", int'(cause_flags[0]), 1);
        clr_flags(3'b111);

        // R2 / R4: long low holds reset, software write ignored meanwhile
        ext_rst_n = 1'b0;
        tick(30 * 4);
        chk(int_rst == 1'b1, "R2 held while pin low", int'(int_rst), 1);
        sw_write(1'b0);
        chk(swrst_rb == 1'b1, "R4 write during reset ignored", int'(swrst_rb), 1);
        tick(10 * 4);
        chk(int_rst == 1'b1, "R2 still held", int'(int_rst), 1);
        ext_rst_n = 1'b1;
        wait_release(n);
        chk(n <= 24, "R6 run-mode release", n, 24);
        snap = rst_clks;
        tick(12);
        chk(rst_clks == snap, "R4 no late software reset", int'(rst_clks - snap), 0);

        // R4 / R3: software reset, pin flag still set from before
        sw_write(1'b0);
        chk(swrst_rb == 1'b0, "R4 sw bit reads 0 pending", int'(swrst_rb), 0);
        tick(1);
        chk(int_rst == 1'b1, "R4 sw reset starts", int'(int_rst), 1);
        chk(swrst_rb == 1'b1, "R4 sw bit restored", int'(swrst_rb), 1);
        wait_release(n);
        chk(n >= 10 && n <= 22, "R3 minimum hold length", n, 16);
        chk(cause_flags == 3'b011, "R10 flags survive reset", int'(cause_flags), 3);
        clr_flags(3'b001);
        chk(cause_flags == 3'b010, "R10 selective clear", int'(cause_flags), 2);
        clr_flags(3'b010);
        chk(cause_flags == 3'b000, "R10 all clear", int'(cause_flags), 0);

        // R5: software reset in stop mode has no settling wait
        clk_mode = 2'b01;
        sw_write(1'b0);
        tick(1);
        wait_release(n);
        chk(n <= 22, "R5 no wait for software reset", n, 16);
        clk_mode = 2'b00;
        clr_flags(3'b111);

        // R4: writing 1 does nothing
        snap = rst_clks;
        sw_write(1'b1);
        tick(10);
        chk(rst_clks == snap && swrst_rb == 1'b1, "R4 write of 1 no effect", int'(rst_clks - snap), 0);

        // R8: deferral until the write ends
        wr_busy = 1'b1;
        snap = rst_clks;
        pin_pulse(20);
        tick(40);
        chk(rst_clks == snap, "R8 deferred while busy", int'(rst_clks - snap), 0);
        wr_busy = 1'b0;
        tick(2);
        chk(int_rst == 1'b1, "R8 accepted after write", int'(int_rst), 1);
        wait_release(n);
        chk(cause_flags == 3'b001, "R8 pin flag only", int'(cause_flags), 1);
        clr_flags(3'b111);

        // R9: bus stall forces acceptance
        wr_busy = 1'b1;
        pin_pulse(20);
        bus_ext = 1'b1;
        bus_rdy = 1'b0;
        tick(10 * 4);
        chk(int_rst == 1'b0, "R9 short stall no force", int'(int_rst), 0);
        tick(7 * 4);
        chk(int_rst == 1'b1, "R9 forced acceptance", int'(int_rst), 1);
        bus_ext = 1'b0;
        bus_rdy = 1'b1;
        wr_busy = 1'b0;
        wait_release(n);
        chk(cause_flags == 3'b101, "R9 stall flag", int'(cause_flags), 5);
        clr_flags(3'b111);

        // R7 / R6: settling wait per clock mode
        for (int m = 1; m < 4; m++) begin
            clk_mode = 2'(m);
            pin_pulse(20);
            wait_release(n);
            if (exp_wait(clk_mode))
                chk(n >= STAB_CLK && n <= STAB_CLK + 30, "R7 settling wait", n, STAB_CLK);
            else
                chk(n <= 24, "R6 reserved mode no wait", n, 24);
            clr_flags(3'b111);
        end

        // Random pulse lengths and clock modes (R1, R6, R7)
        for (int i = 0; i < 14; i++) begin
            int len;
            bit exp_r;
            len = 8 + int'($urandom % 17);
            clk_mode = 2'($urandom % 4);
            exp_r = exp_accept(len);
            snap = rst_clks;
            pin_pulse(len);
            tick(4);
            chk((rst_clks != snap) == exp_r, "R1 random pulse", int'(rst_clks != snap), int'(exp_r));
            if (exp_r) begin
                wait_release(n);
                n = n + 4;
                if (exp_wait(clk_mode))
                    chk(n >= STAB_CLK && n <= STAB_CLK + 40, "R7 random wait", n, STAB_CLK);
                else
                    chk(n <= 24, "R6 random release", n, 24);
            end
            chk(cause_flags[0] == exp_r, "R1 random flag", int'(cause_flags[0]), int'(exp_r));
            clr_flags(3'b111);
            tick(3);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule